// File: doc/BRIEF.md
# Doubleword Move Execute Unit

This block carries out a 32-bit move between a scalar location and a wide register. A scalar location is a general-purpose register or a memory word. A wide register is either a 64-bit multimedia register or a 128-bit vector register.

The two opcode bytes after the escape byte set the direction. The load form copies the scalar value into the low 32 bits of a wide register and clears all the bits above. The store form takes the low 32 bits of a wide register and sends them to a general register or to memory. An operand-size prefix flag picks the 128-bit vector file; without it the 64-bit multimedia file is used.

Before any state is committed, the unit checks the control bits, the feature bits and the address-check results supplied by earlier pipeline stages. When several faults apply, it reports only the one with the highest priority. A faulting instruction writes nothing. Each accepted instruction produces its results one clock later as single-cycle write strobes.

Top module: `dword_xfer_unit`

## Requirements
- R1: A load (escape 0x0F, opcode 0x6E) with the prefix clear pulses `mm_we` and drives `mm_wdata` with the scalar source in bits 31:0 and zeros in bits 63:32.
- R2: A load with the prefix set pulses `xmm_we` and drives `xmm_wdata` with the scalar source in bits 31:0 and zeros in bits 127:32.
- R3: A store (escape 0x0F, opcode 0x7E) drives `scalar_wdata` with bits 31:0 of `src_wide`. It pulses `gpr_we` when `mem_op` is 0 and `mem_we` when `mem_op` is 1. The prefix only selects which register file was read.
- R4: Results appear on the clock edge after the edge that samples `in_valid` high. A non-faulting instruction asserts exactly one write enable for exactly one cycle. No write enable and no fault appears in a cycle that follows one with `in_valid` low.
- R5: Undefined-opcode fault (code 1) in either of two cases. The first is an escape byte other than 0x0F, or an opcode other than 0x6E or 0x7E. The second is a prefixed (vector) form while `ctl_emul` is 1, `ctl_osvec` is 0 or `feat_vec` is 0.
- R6: Device-not-available fault (code 2) for any legal form while `ctl_ts` is 1.
- R7: Floating-point error fault (code 3) for an unprefixed form while `fpu_pending` is 1. Prefixed forms ignore `fpu_pending`.
- R8: With `mem_op` set, `mem_limit` raises code 5 (stack fault) if `mem_stack` is 1 and otherwise code 4 (general protection). A store to memory with `mem_ro` set raises code 4. All memory inputs are ignored when `mem_op` is 0.
- R9: An alignment fault (code 6) is raised when `mem_op`, `mem_unaligned` and `align_en` are all 1 and `cpl` equals 3.
- R10: Priority runs undefined-opcode, device-not-available, floating-point error, limit fault, read-only fault, then alignment. `fault_vld` pulses with the winning code, and every write enable stays low for that instruction. Code 0 means no fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction presented this cycle |
| esc_byte | input | 8 | First opcode byte |
| op_byte | input | 8 | Second opcode byte |
| pfx_vec | input | 1 | Operand-size prefix present (selects vector file) |
| src_scalar | input | 32 | GPR or memory value for the load form |
| src_wide | input | 128 | Wide register read value for the store form (multimedia value in low 64 bits) |
| ctl_emul | input | 1 | Emulation control bit |
| ctl_osvec | input | 1 | OS vector-state support bit |
| feat_vec | input | 1 | Vector feature flag |
| ctl_ts | input | 1 | Task-switched control bit |
| fpu_pending | input | 1 | Pending floating-point exception |
| mem_op | input | 1 | Scalar operand is in memory |
| mem_limit | input | 1 | Effective address outside segment limit |
| mem_stack | input | 1 | Operand addressed through the stack segment |
| mem_ro | input | 1 | Target segment not writable |
| mem_unaligned | input | 1 | Memory reference unaligned |
| align_en | input | 1 | Alignment checking enabled |
| cpl | input | 2 | Current privilege level |
| mm_we | output | 1 | Multimedia register write strobe |
| mm_wdata | output | 64 | Multimedia register write value |
| xmm_we | output | 1 | Vector register write strobe |
| xmm_wdata | output | 128 | Vector register write value |
| gpr_we | output | 1 | General register write strobe |
| mem_we | output | 1 | Memory write strobe |
| scalar_wdata | output | 32 | Value for GPR or memory |
| fault_vld | output | 1 | Fault reported this cycle |
| fault_code | output | 3 | Winning fault code (0 none, 1 undefined, 2 device, 3 FP error, 4 protection, 5 stack, 6 alignment) |

## Verification
The assertions check several properties on every cycle. At most one write strobe is active at a time. A fault never coincides with a write. Results appear only after an accepted instruction, and a non-faulting instruction produces exactly one strobe. The upper bits of both wide write values are zero whenever they are written. The task-switched and pending-FP cases must report the right code. The bench's scenarios are what show the full priority ordering across overlapping fault conditions. They also cover the exact data values carried through each path, the choice between GPR and memory for stores, and the fact that memory checks are ignored for register operands.

// File: rtl/dxu_pkg.sv
package dxu_pkg;

   typedef enum logic [2:0] {
      FLT_NONE = 3'd0,
      FLT_UD   = 3'd1,
      FLT_NM   = 3'd2,
      FLT_MF   = 3'd3,
      FLT_GP   = 3'd4,
      FLT_SS   = 3'd5,
      FLT_AC   = 3'd6
   } flt_e;

   typedef struct packed {
      logic legal;    // recognised escape and opcode
      logic to_wide;  // load direction
      logic vec;      // vector file selected
   } dec_t;

   localparam logic [1:0] USER_CPL = 2'd3;

endpackage

// File: rtl/dxu_decode.sv
module dxu_decode
   import dxu_pkg::*;
#(
   parameter logic [7:0] ESC_CODE   = 8'h0F,
   parameter logic [7:0] LOAD_CODE  = 8'h6E,
   parameter logic [7:0] STORE_CODE = 8'h7E
) (
   input  logic [7:0] esc_byte,
   input  logic [7:0] op_byte,
   input  logic       pfx_vec,
   output dec_t       dec
);
   logic is_ld, is_st;

   assign is_ld = (op_byte == LOAD_CODE);
   assign is_st = (op_byte == STORE_CODE);

   always_comb begin
      dec.legal   = (esc_byte == ESC_CODE) && (is_ld || is_st);
      dec.to_wide = is_ld;
      dec.vec     = pfx_vec;
   end
endmodule

// File: rtl/dxu_fault_arb.sv
module dxu_fault_arb
   import dxu_pkg::*;
(
   input  dec_t       dec,
   input  logic       ctl_emul,
   input  logic       ctl_osvec,
   input  logic       feat_vec,
   input  logic       ctl_ts,
   input  logic       fpu_pending,
   input  logic       mem_op,
   input  logic       mem_limit,
   input  logic       mem_stack,
   input  logic       mem_ro,
   input  logic       mem_unaligned,
   input  logic       align_en,
   input  logic [1:0] cpl,
   output flt_e       flt
);
   logic vec_off, ro_hit, ac_hit;

   assign vec_off = dec.vec && (ctl_emul || !ctl_osvec || !feat_vec);
   assign ro_hit  = mem_op && !dec.to_wide && mem_ro;
   assign ac_hit  = mem_op && mem_unaligned && align_en && (cpl == USER_CPL);

   always_comb begin
      if (!dec.legal || vec_off)       flt = FLT_UD;
      else if (ctl_ts)                 flt = FLT_NM;
      else if (!dec.vec && fpu_pending) flt = FLT_MF;
      else if (mem_op && mem_limit)    flt = mem_stack ? FLT_SS : FLT_GP;
      else if (ro_hit)                 flt = FLT_GP;
      else if (ac_hit)                 flt = FLT_AC;
      else                             flt = FLT_NONE;
   end
endmodule

// File: rtl/dxu_zext.sv
module dxu_zext #(
   parameter int IN_W  = 32,
   parameter int OUT_W = 64
) (
   input  logic [IN_W-1:0]  din,
   output logic [OUT_W-1:0] dout
);
   localparam int PAD_W = OUT_W - IN_W;

   if (OUT_W < IN_W) begin : g_bad
      $error("dxu_zext: OUT_W must not be below IN_W");
   end else if (PAD_W == 0) begin : g_pass
      assign dout = din;
   end else begin : g_pad
      assign dout = {{PAD_W{1'b0}}, din};
   end
endmodule

// File: rtl/dword_xfer_unit.sv
module dword_xfer_unit
   import dxu_pkg::*;
#(
   parameter int         SCALAR_W   = 32,
   parameter int         MM_W       = 64,
   parameter int         VEC_W      = 128,
   parameter logic [7:0] ESC_CODE   = 8'h0F,
   parameter logic [7:0] LOAD_CODE  = 8'h6E,
   parameter logic [7:0] STORE_CODE = 8'h7E
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                in_valid,
   input  logic [7:0]          esc_byte,
   input  logic [7:0]          op_byte,
   input  logic                pfx_vec,
   input  logic [SCALAR_W-1:0] src_scalar,
   input  logic [VEC_W-1:0]    src_wide,
   input  logic                ctl_emul,
   input  logic                ctl_osvec,
   input  logic                feat_vec,
   input  logic                ctl_ts,
   input  logic                fpu_pending,
   input  logic                mem_op,
   input  logic                mem_limit,
   input  logic                mem_stack,
   input  logic                mem_ro,
   input  logic                mem_unaligned,
   input  logic                align_en,
   input  logic [1:0]          cpl,
   output logic                mm_we,
   output logic [MM_W-1:0]     mm_wdata,
   output logic                xmm_we,
   output logic [VEC_W-1:0]    xmm_wdata,
   output logic                gpr_we,
   output logic                mem_we,
   output logic [SCALAR_W-1:0] scalar_wdata,
   output logic                fault_vld,
   output logic [2:0]          fault_code
);
   if (MM_W <= SCALAR_W || VEC_W <= MM_W) begin : g_width_chk
      $error("dword_xfer_unit: need SCALAR_W < MM_W < VEC_W");
   end
   if (LOAD_CODE == STORE_CODE) begin : g_code_chk
      $error("dword_xfer_unit: load and store opcodes must differ");
   end

   dec_t                dec;
   flt_e                flt;
   logic [MM_W-1:0]     mm_ext;
   logic [VEC_W-1:0]    vec_ext;
   logic [SCALAR_W-1:0] wide_low;

   dxu_decode #(
      .ESC_CODE   (ESC_CODE),
      .LOAD_CODE  (LOAD_CODE),
      .STORE_CODE (STORE_CODE)
   ) u_dec (
      .esc_byte (esc_byte),
      .op_byte  (op_byte),
      .pfx_vec  (pfx_vec),
      .dec      (dec)
   );

   dxu_fault_arb u_arb (
      .dec           (dec),
      .ctl_emul      (ctl_emul),
      .ctl_osvec     (ctl_osvec),
      .feat_vec      (feat_vec),
      .ctl_ts        (ctl_ts),
      .fpu_pending   (fpu_pending),
      .mem_op        (mem_op),
      .mem_limit     (mem_limit),
      .mem_stack     (mem_stack),
      .mem_ro        (mem_ro),
      .mem_unaligned (mem_unaligned),
      .align_en      (align_en),
      .cpl           (cpl),
      .flt           (flt)
   );

   dxu_zext #(.IN_W(SCALAR_W), .OUT_W(MM_W)) u_zext_mm (
      .din  (src_scalar),
      .dout (mm_ext)
   );

   dxu_zext #(.IN_W(SCALAR_W), .OUT_W(VEC_W)) u_zext_vec (
      .din  (src_scalar),
      .dout (vec_ext)
   );

   // Both wide files keep their low doubleword at the bottom of src_wide.
   assign wide_low = src_wide[SCALAR_W-1:0];

   logic commit;
   assign commit = in_valid && (flt == FLT_NONE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mm_we        <= 1'b0;
         xmm_we       <= 1'b0;
         gpr_we       <= 1'b0;
         mem_we       <= 1'b0;
         mm_wdata     <= '0;
         xmm_wdata    <= '0;
         scalar_wdata <= '0;
         fault_vld    <= 1'b0;
         fault_code   <= FLT_NONE;
      end else begin
         mm_we      <= commit &&  dec.to_wide && !dec.vec;
         xmm_we     <= commit &&  dec.to_wide &&  dec.vec;
         gpr_we     <= commit && !dec.to_wide && !mem_op;
         mem_we     <= commit && !dec.to_wide &&  mem_op;
         fault_vld  <= in_valid && (flt != FLT_NONE);
         fault_code <= in_valid ? flt : FLT_NONE;
         if (in_valid) begin
            mm_wdata     <= mm_ext;
            xmm_wdata    <= vec_ext;
            scalar_wdata <= wide_low;
         end
      end
   end
endmodule

// File: rtl/dword_xfer_unit_chk.sv
module dword_xfer_unit_chk #(
   parameter int SCALAR_W = 32,
   parameter int MM_W     = 64,
   parameter int VEC_W    = 128
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_valid,
   input logic             pfx_vec,
   input logic [7:0]       esc_byte,
   input logic [7:0]       op_byte,
   input logic             ctl_ts,
   input logic             fpu_pending,
   input logic             mm_we,
   input logic [MM_W-1:0]  mm_wdata,
   input logic             xmm_we,
   input logic [VEC_W-1:0] xmm_wdata,
   input logic             gpr_we,
   input logic             mem_we,
   input logic             fault_vld,
   input logic [2:0]       fault_code
);
   logic any_we;
   assign any_we = mm_we || xmm_we || gpr_we || mem_we;

   // R4: never more than one strobe
   a_r4_single_we: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({mm_we, xmm_we, gpr_we, mem_we}));

   // R4: nothing appears without an accepted instruction
   a_r4_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(in_valid) |-> (!any_we && !fault_vld));

   // R4: an accepted, non-faulting instruction yields a strobe
   a_r4_one_result: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(in_valid) && !fault_vld) |-> $countones({mm_we, xmm_we, gpr_we, mem_we}) == 1);

   // R10: a fault suppresses every write
   a_r10_fault_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      fault_vld |-> !any_we);

   // R10: a reported fault carries a nonzero code
   a_r10_code_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
      fault_vld |-> fault_code != 3'd0);

   // R1: upper multimedia bits cleared
   a_r1_mm_zext: assert property (@(posedge clk) disable iff (!rst_n)
      mm_we |-> mm_wdata[MM_W-1:SCALAR_W] == '0);

   // R2: upper vector bits cleared
   a_r2_vec_zext: assert property (@(posedge clk) disable iff (!rst_n)
      xmm_we |-> xmm_wdata[VEC_W-1:SCALAR_W] == '0);

   // R6: task-switched on a legal unprefixed form
   a_r6_ts_fault: assert property (@(posedge clk) disable iff (!rst_n)
      $past(in_valid && ctl_ts && !pfx_vec && esc_byte == 8'h0F
            && (op_byte == 8'h6E || op_byte == 8'h7E))
      |-> (fault_vld && fault_code == 3'd2));

   // R7: pending FP error on an unprefixed legal form without ts
   a_r7_mf_fault: assert property (@(posedge clk) disable iff (!rst_n)
      $past(in_valid && !ctl_ts && fpu_pending && !pfx_vec && esc_byte == 8'h0F
            && (op_byte == 8'h6E || op_byte == 8'h7E))
      |-> (fault_vld && fault_code == 3'd3));
endmodule

bind dword_xfer_unit dword_xfer_unit_chk #(
   .SCALAR_W (SCALAR_W),
   .MM_W     (MM_W),
   .VEC_W    (VEC_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .in_valid    (in_valid),
   .pfx_vec     (pfx_vec),
   .esc_byte    (esc_byte),
   .op_byte     (op_byte),
   .ctl_ts      (ctl_ts),
   .fpu_pending (fpu_pending),
   .mm_we       (mm_we),
   .mm_wdata    (mm_wdata),
   .xmm_we      (xmm_we),
   .xmm_wdata   (xmm_wdata),
   .gpr_we      (gpr_we),
   .mem_we      (mem_we),
   .fault_vld   (fault_vld),
   .fault_code  (fault_code)
);

// File: tb/tb_dword_xfer_unit.sv
`timescale 1ns/1ps
module tb_dword_xfer_unit;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_valid = 1'b0;
   logic [7:0]   esc_byte = 8'h0F, op_byte = 8'h6E;
   logic         pfx_vec = 1'b0;
   logic [31:0]  src_scalar = '0;
   logic [127:0] src_wide = '0;
   logic ctl_emul = 0, ctl_osvec = 1, feat_vec = 1, ctl_ts = 0, fpu_pending = 0;
   logic mem_op = 0, mem_limit = 0, mem_stack = 0, mem_ro = 0, mem_unaligned = 0, align_en = 0;
   logic [1:0]   cpl = 2'd0;
   logic         mm_we, xmm_we, gpr_we, mem_we, fault_vld;
   logic [63:0]  mm_wdata;
   logic [127:0] xmm_wdata;
   logic [31:0]  scalar_wdata;
   logic [2:0]   fault_code;

   int n_tests = 0;
   int n_fail  = 0;

   always #2 clk = ~clk;

   dword_xfer_unit dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .esc_byte(esc_byte),
      .op_byte(op_byte), .pfx_vec(pfx_vec), .src_scalar(src_scalar), .src_wide(src_wide),
      .ctl_emul(ctl_emul), .ctl_osvec(ctl_osvec), .feat_vec(feat_vec), .ctl_ts(ctl_ts),
      .fpu_pending(fpu_pending), .mem_op(mem_op), .mem_limit(mem_limit),
      .mem_stack(mem_stack), .mem_ro(mem_ro), .mem_unaligned(mem_unaligned),
      .align_en(align_en), .cpl(cpl), .mm_we(mm_we), .mm_wdata(mm_wdata),
      .xmm_we(xmm_we), .xmm_wdata(xmm_wdata), .gpr_we(gpr_we), .mem_we(mem_we),
      .scalar_wdata(scalar_wdata), .fault_vld(fault_vld), .fault_code(fault_code)
   );

   // Expected fault code from the requirement text (R5..R10)
   function automatic logic [2:0] ref_fault();
      logic legal, load;
      legal = (esc_byte == 8'h0F) && (op_byte == 8'h6E || op_byte == 8'h7E);
      load  = (op_byte == 8'h6E);
      if (!legal) return 3'd1;
      if (pfx_vec && (ctl_emul || !ctl_osvec || !feat_vec)) return 3'd1;
      if (ctl_ts) return 3'd2;
      if (!pfx_vec && fpu_pending) return 3'd3;
      if (mem_op) begin
         if (mem_limit) return mem_stack ? 3'd5 : 3'd4;
         if (!load && mem_ro) return 3'd4;
         if (mem_unaligned && align_en && cpl == 2'd3) return 3'd6;
      end
      return 3'd0;
   endfunction

   function automatic string tag_of(input logic [2:0] f);
      case (f)
         3'd1: return "R5";
         3'd2: return "R6";
         3'd3: return "R7";
         3'd4, 3'd5: return "R8";
         3'd6: return "R9";
         default: return (op_byte == 8'h6E) ? (pfx_vec ? "R2" : "R1") : "R3";
      endcase
   endfunction

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // Drive the current inputs as one instruction and check the result.
   task automatic issue();
      logic [2:0] ef;
      logic [7:0] estat, astat;
      string tg;
      @(negedge clk);
      ef = ref_fault();
      tg = tag_of(ef);
      estat = {(ef != 0), ef, 4'b0000};
      if (ef == 0) begin
         if (op_byte == 8'h6E) estat[3:0] = pfx_vec ? 4'b0100 : 4'b1000;
         else                  estat[3:0] = mem_op  ? 4'b0001 : 4'b0010;
      end
      in_valid = 1'b1;
      @(posedge clk); #1;
      astat = {fault_vld, fault_code, mm_we, xmm_we, gpr_we, mem_we};
      check({tg, " status"}, {56'd0, astat}, {56'd0, estat});
      if (ef == 0 && op_byte == 8'h6E && !pfx_vec)
         check("R1 data", mm_wdata, {32'd0, src_scalar});
      if (ef == 0 && op_byte == 8'h6E && pfx_vec) begin
         check("R2 data lo", xmm_wdata[63:0], {32'd0, src_scalar});
         check("R2 data hi", xmm_wdata[127:64], 64'd0);
      end
      if (ef == 0 && op_byte == 8'h7E)
         check("R3 data", {32'd0, scalar_wdata}, {32'd0, src_wide[31:0]});
      @(negedge clk);
      in_valid = 1'b0;
      @(posedge clk); #1;
      check("R4 idle", {60'd0, mm_we, xmm_we, gpr_we, mem_we}, 64'd0);
      check("R4 idle fault", {63'd0, fault_vld}, 64'd0);
   endtask

   task automatic clean(input logic [7:0] op, input logic pv);
      esc_byte = 8'h0F; op_byte = op; pfx_vec = pv;
      ctl_emul = 0; ctl_osvec = 1; feat_vec = 1; ctl_ts = 0; fpu_pending = 0;
      mem_op = 0; mem_limit = 0; mem_stack = 0; mem_ro = 0;
      mem_unaligned = 0; align_en = 0; cpl = 2'd0;
      src_scalar = $urandom; src_wide = {$urandom, $urandom, $urandom, $urandom};
   endtask

   initial begin
      #800000;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'h1357_2468));
      repeat (3) @(posedge clk);
      #1;
      check("R4 reset", {55'd0, mm_we, xmm_we, gpr_we, mem_we, fault_vld, fault_code, 1'b0},
            64'd0);
      @(negedge clk); rst_n = 1'b1;

      // Directed corners
      clean(8'h6E, 0); src_scalar = 32'hFFFF_FFFF; issue();          // R1
      clean(8'h6E, 1); src_scalar = 32'h8000_0001; issue();          // R2
      clean(8'h7E, 0); src_wide = {128{1'b1}}; issue();              // R3 GPR
      clean(8'h7E, 1); mem_op = 1; issue();                          // R3 memory
      clean(8'h7E, 0); mem_ro = 1; mem_limit = 0; issue();           // R8 ignored (register)
      clean(8'h7E, 0); mem_op = 1; mem_ro = 1; issue();              // R8 read-only
      clean(8'h6E, 0); mem_op = 1; mem_ro = 1; issue();              // R8 load ignores ro
      clean(8'h6E, 1); mem_op = 1; mem_limit = 1; mem_stack = 1; issue(); // R8 stack
      clean(8'h6E, 1); mem_op = 1; mem_unaligned = 1; align_en = 1; cpl = 3; issue(); // R9
      clean(8'h6E, 1); mem_op = 1; mem_unaligned = 1; align_en = 1; cpl = 2; issue(); // R9 off
      clean(8'h6E, 1); feat_vec = 0; ctl_ts = 1; issue();            // R5 over R6 (R10)
      clean(8'h6E, 0); feat_vec = 0; ctl_emul = 1; issue();          // R5 only vector forms
      clean(8'h6E, 0); ctl_ts = 1; fpu_pending = 1; issue();         // R6 over R7 (R10)
      clean(8'h7E, 1); fpu_pending = 1; issue();                     // R7 ignored for vector
      clean(8'h7E, 0); fpu_pending = 1; mem_op = 1; mem_limit = 1; issue(); // R7 over R8
      clean(8'h7E, 0); mem_op = 1; mem_limit = 1; mem_ro = 1; issue(); // R10 limit first
      clean(8'h10, 0); issue();                                      // R5 bad opcode
      clean(8'h6E, 0); esc_byte = 8'h0E; issue();                    // R5 bad escape

      // Constrained random
      for (int i = 0; i < 3000; i++) begin
         clean(($urandom % 5 == 0) ? 8'($urandom) : (($urandom % 2) ? 8'h6E : 8'h7E),
               1'($urandom));
         if ($urandom % 16 == 0) esc_byte = 8'($urandom);
         ctl_emul      = ($urandom % 8 == 0);
         ctl_osvec     = ($urandom % 8 != 0);
         feat_vec      = ($urandom % 8 != 0);
         ctl_ts        = ($urandom % 8 == 0);
         fpu_pending   = ($urandom % 6 == 0);
         mem_op        = 1'($urandom);
         mem_limit     = ($urandom % 6 == 0);
         mem_stack     = 1'($urandom);
         mem_ro        = ($urandom % 5 == 0);
         mem_unaligned = ($urandom % 4 == 0);
         align_en      = 1'($urandom);
         cpl           = 2'($urandom);
         issue();
      end

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule